// File: doc/BRIEF.md
# Shift-in and carry-in selector with paired shift registers

This block serves an 8-bit datapath that has two shiftable registers. One is the register-file write path, called RF here. The other is the Q register. Each register holds, loads, or shifts by one place. The shift runs toward the MSB or toward the LSB, as one shared direction line selects. The block decides which serial bit enters each register on a shift. It draws that bit from an 8-way source list: constants, the register's own outgoing bit (rotate), the other register's outgoing bit (chaining), a latched flag in true or inverted form, and the ALU carry and sign flags.

The block also picks the ALU carry-in. The candidates are the same constants, either register's outgoing bit, and the ALU flags. The outgoing end bit of each register is a combinational output, so neighbouring logic can always see the bit that a shift would remove. The ALU arithmetic is outside this block.

Top module: `sc_shift_unit`

## Requirements
- R1: A synchronous active-high `rst` clears both registers to zero at the next rising clock edge, whatever the other inputs are.
- R2: The 2-bit per-register op field works as follows at the rising edge: 2'b00 holds, 2'b01 loads the parallel data, 2'b10 shifts by one place, and 2'b11 holds.
- R3: With `dir_up`=1 a shift moves every bit one place toward the MSB, the serial bit enters bit 0, and the outgoing bit is the MSB. With `dir_up`=0 bits move toward the LSB, the serial bit enters the MSB, and the outgoing bit is bit 0.
- R4: Each shift-out output is combinational from the current register contents and `dir_up`. It shows the end bit even on cycles when that register does not shift.
- R5: Shift-in select code 0 inserts 0 and code 1 inserts 1.
- R6: Shift-in select code 2 inserts the register's own shift-out, so the shift becomes a rotate.
- R7: Shift-in select code 3 inserts the other register's shift-out, which chains RF and Q.
- R8: Shift-in select code 4 inserts the inverted latched flag and code 5 inserts the true latched flag.
- R9: Shift-in select code 6 inserts the ALU carry flag and code 7 inserts the ALU sign flag.
- R10: The carry-in select drives `carry_in` as follows: code 0 gives 0, code 1 gives 1, code 2 gives the RF shift-out, code 3 gives the Q shift-out, code 6 gives the ALU carry, and code 7 gives the ALU sign.
- R11: Carry-in select codes 4 and 5 drive `carry_in` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| dir_up | input | 1 | 1 shifts toward MSB, 0 toward LSB |
| rf_op | input | 2 | RF register operation |
| q_op | input | 2 | Q register operation |
| rf_load_data | input | WIDTH | Parallel load value for RF |
| q_load_data | input | WIDTH | Parallel load value for Q |
| rf_sin_sel | input | 3 | RF serial-input source code |
| q_sin_sel | input | 3 | Q serial-input source code |
| cin_sel | input | 3 | ALU carry-in source code |
| alu_carry | input | 1 | ALU carry-out flag |
| alu_sign | input | 1 | ALU sign flag |
| flag_latched | input | 1 | Flag bit latched by the previous cycle |
| rf_value | output | WIDTH | RF register contents |
| q_value | output | WIDTH | Q register contents |
| rf_shift_out | output | 1 | Bit that an RF shift would remove |
| q_shift_out | output | 1 | Bit that a Q shift would remove |
| carry_in | output | 1 | Selected ALU carry-in |

## Verification
The properties assume that every control input has a known value on each sampled edge outside reset. They also assume that `dir_up`, the op fields and the select codes stay steady from the falling edge to the next rising edge. The bench meets both assumptions because it changes every input only on the falling edge and draws each input from its full legal code range. In the random phase it also pulses reset now and then, so the properties restart from a cleared state.

// File: rtl/sc_shift_pkg.sv
package sc_shift_pkg;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'b00,
      OP_LOAD  = 2'b01,
      OP_SHIFT = 2'b10,
      OP_IDLE  = 2'b11
   } reg_op_e;

   typedef enum logic [2:0] {
      SIN_ZERO    = 3'd0,
      SIN_ONE     = 3'd1,
      SIN_ROTATE  = 3'd2,
      SIN_CROSS   = 3'd3,
      SIN_FLAG_N  = 3'd4,
      SIN_FLAG    = 3'd5,
      SIN_CARRY   = 3'd6,
      SIN_SIGN    = 3'd7
   } sin_sel_e;

   typedef enum logic [2:0] {
      CIN_ZERO  = 3'd0,
      CIN_ONE   = 3'd1,
      CIN_RF    = 3'd2,
      CIN_Q     = 3'd3,
      CIN_RSV4  = 3'd4,
      CIN_RSV5  = 3'd5,
      CIN_CARRY = 3'd6,
      CIN_SIGN  = 3'd7
   } cin_sel_e;

endpackage

// File: rtl/sc_sin_mux.sv
module sc_sin_mux
   import sc_shift_pkg::*;
(
   input  logic [2:0] sel,
   input  logic       own_out,
   input  logic       other_out,
   input  logic       flag,
   input  logic       carry,
   input  logic       sign,
   output logic       sin
);
   always_comb begin
      unique case (sin_sel_e'(sel))
         SIN_ZERO   : sin = 1'b0;
         SIN_ONE    : sin = 1'b1;
         SIN_ROTATE : sin = own_out;
         SIN_CROSS  : sin = other_out;
         SIN_FLAG_N : sin = ~flag;
         SIN_FLAG   : sin = flag;
         SIN_CARRY  : sin = carry;
         SIN_SIGN   : sin = sign;
         default    : sin = 1'b0;
      endcase
   end
endmodule

// File: rtl/sc_cin_mux.sv
module sc_cin_mux
   import sc_shift_pkg::*;
(
   input  logic [2:0] sel,
   input  logic       rf_out,
   input  logic       q_out,
   input  logic       carry,
   input  logic       sign,
   output logic       cin
);
   always_comb begin
      unique case (cin_sel_e'(sel))
         CIN_ZERO  : cin = 1'b0;
         CIN_ONE   : cin = 1'b1;
         CIN_RF    : cin = rf_out;
         CIN_Q     : cin = q_out;
         CIN_CARRY : cin = carry;
         CIN_SIGN  : cin = sign;
         default   : cin = 1'b0;
      endcase
   end
endmodule

// File: rtl/sc_serial_reg.sv
module sc_serial_reg
   import sc_shift_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       op,
   input  logic             dir_up,
   input  logic [WIDTH-1:0] load_data,
   input  logic             serial_in,
   output logic [WIDTH-1:0] value,
   output logic             serial_out
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] shifted;

   generate
      if (WIDTH < 2) begin : g_width_bad
         initial $fatal(1, "sc_serial_reg: WIDTH must be at least 2");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (i == 0) begin : g_low
            assign shifted[i] = dir_up ? serial_in : value[i+1];
         end else if (i == MSB) begin : g_high
            assign shifted[i] = dir_up ? value[i-1] : serial_in;
         end else begin : g_mid
            assign shifted[i] = dir_up ? value[i-1] : value[i+1];
         end
      end
   endgenerate

   assign serial_out = dir_up ? value[MSB] : value[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         value <= '0;
      end else begin
         unique case (reg_op_e'(op))
            OP_LOAD  : value <= load_data;
            OP_SHIFT : value <= shifted;
            default  : value <= value;
         endcase
      end
   end
endmodule

// File: rtl/sc_shift_unit.sv
module sc_shift_unit
   import sc_shift_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dir_up,
   input  logic [1:0]       rf_op,
   input  logic [1:0]       q_op,
   input  logic [WIDTH-1:0] rf_load_data,
   input  logic [WIDTH-1:0] q_load_data,
   input  logic [2:0]       rf_sin_sel,
   input  logic [2:0]       q_sin_sel,
   input  logic [2:0]       cin_sel,
   input  logic             alu_carry,
   input  logic             alu_sign,
   input  logic             flag_latched,
   output logic [WIDTH-1:0] rf_value,
   output logic [WIDTH-1:0] q_value,
   output logic             rf_shift_out,
   output logic             q_shift_out,
   output logic             carry_in
);
   logic rf_sin;
   logic q_sin;

   sc_sin_mux u_rf_sin (
      .sel       (rf_sin_sel),
      .own_out   (rf_shift_out),
      .other_out (q_shift_out),
      .flag      (flag_latched),
      .carry     (alu_carry),
      .sign      (alu_sign),
      .sin       (rf_sin)
   );

   sc_sin_mux u_q_sin (
      .sel       (q_sin_sel),
      .own_out   (q_shift_out),
      .other_out (rf_shift_out),
      .flag      (flag_latched),
      .carry     (alu_carry),
      .sign      (alu_sign),
      .sin       (q_sin)
   );

   sc_serial_reg #(.WIDTH(WIDTH)) u_rf_reg (
      .clk        (clk),
      .rst        (rst),
      .op         (rf_op),
      .dir_up     (dir_up),
      .load_data  (rf_load_data),
      .serial_in  (rf_sin),
      .value      (rf_value),
      .serial_out (rf_shift_out)
   );

   sc_serial_reg #(.WIDTH(WIDTH)) u_q_reg (
      .clk        (clk),
      .rst        (rst),
      .op         (q_op),
      .dir_up     (dir_up),
      .load_data  (q_load_data),
      .serial_in  (q_sin),
      .value      (q_value),
      .serial_out (q_shift_out)
   );

   sc_cin_mux u_cin (
      .sel    (cin_sel),
      .rf_out (rf_shift_out),
      .q_out  (q_shift_out),
      .carry  (alu_carry),
      .sign   (alu_sign),
      .cin    (carry_in)
   );
endmodule

// File: rtl/sc_shift_unit_chk.sv
module sc_shift_unit_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             dir_up,
   input logic [1:0]       rf_op,
   input logic [1:0]       q_op,
   input logic [WIDTH-1:0] rf_load_data,
   input logic [2:0]       rf_sin_sel,
   input logic [2:0]       q_sin_sel,
   input logic [2:0]       cin_sel,
   input logic             flag_latched,
   input logic [WIDTH-1:0] rf_value,
   input logic [WIDTH-1:0] q_value,
   input logic             rf_shift_out,
   input logic             q_shift_out,
   input logic             carry_in
);
   // R1
   reset_clears_chk: assert property (@(posedge clk)
      rst |=> (rf_value == '0 && q_value == '0));

   // R2
   hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
      (rf_op == 2'b00 || rf_op == 2'b11) |=> $stable(rf_value));

   // R2
   load_takes_chk: assert property (@(posedge clk) disable iff (rst)
      (rf_op == 2'b01) |=> rf_value == $past(rf_load_data));

   // R5
   zero_fill_up_chk: assert property (@(posedge clk) disable iff (rst)
      (rf_op == 2'b10 && dir_up && rf_sin_sel == 3'd0) |=> rf_value[0] == 1'b0);

   // R6
   rotate_up_chk: assert property (@(posedge clk) disable iff (rst)
      (rf_op == 2'b10 && dir_up && rf_sin_sel == 3'd2)
      |=> rf_value == {$past(rf_value[WIDTH-2:0]), $past(rf_value[WIDTH-1])});

   // R8
   flag_down_chk: assert property (@(posedge clk) disable iff (rst)
      (q_op == 2'b10 && !dir_up && q_sin_sel == 3'd5)
      |=> q_value[WIDTH-1] == $past(flag_latched));

   // R10
   cin_q_chk: assert property (@(posedge clk) disable iff (rst)
      (cin_sel == 3'd3) |-> carry_in == q_shift_out);

   // R11
   cin_reserved_chk: assert property (@(posedge clk) disable iff (rst)
      (cin_sel == 3'd4 || cin_sel == 3'd5) |-> carry_in == 1'b0);
endmodule

bind sc_shift_unit sc_shift_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .dir_up       (dir_up),
   .rf_op        (rf_op),
   .q_op         (q_op),
   .rf_load_data (rf_load_data),
   .rf_sin_sel   (rf_sin_sel),
   .q_sin_sel    (q_sin_sel),
   .cin_sel      (cin_sel),
   .flag_latched (flag_latched),
   .rf_value     (rf_value),
   .q_value      (q_value),
   .rf_shift_out (rf_shift_out),
   .q_shift_out  (q_shift_out),
   .carry_in     (carry_in)
);

// File: tb/sc_shift_unit_bench.sv
module sc_shift_unit_bench;
   localparam int W = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst, dir_up, alu_carry, alu_sign, flag_latched;
   logic [1:0]   rf_op, q_op;
   logic [W-1:0] rf_load_data, q_load_data;
   logic [2:0]   rf_sin_sel, q_sin_sel, cin_sel;
   logic [W-1:0] rf_value, q_value;
   logic         rf_shift_out, q_shift_out, carry_in;

   sc_shift_unit #(.WIDTH(W)) u_sc_shift_unit (
      .clk(clk), .rst(rst), .dir_up(dir_up), .rf_op(rf_op), .q_op(q_op),
      .rf_load_data(rf_load_data), .q_load_data(q_load_data),
      .rf_sin_sel(rf_sin_sel), .q_sin_sel(q_sin_sel), .cin_sel(cin_sel),
      .alu_carry(alu_carry), .alu_sign(alu_sign), .flag_latched(flag_latched),
      .rf_value(rf_value), .q_value(q_value), .rf_shift_out(rf_shift_out),
      .q_shift_out(q_shift_out), .carry_in(carry_in)
   );

   int vectors = 0;
   int errors  = 0;
   bit model_ok = 0;
   int m_rf, m_q;
   string rf_tag = "R1", q_tag = "R1";

   task automatic check(string tag, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int end_bit(int v, bit up);
      return up ? ((v >> (W - 1)) & 1) : (v & 1);
   endfunction

   function automatic int pick_sin(int code, int own, int other);
      case (code)
         0: return 0;
         1: return 1;
         2: return own;
         3: return other;
         4: return flag_latched ? 0 : 1;
         5: return int'(flag_latched);
         6: return int'(alu_carry);
         default: return int'(alu_sign);
      endcase
   endfunction

   function automatic string sin_tag(int code);
      case (code)
         0, 1: return "R5";
         2: return "R6";
         3: return "R7";
         4, 5: return "R8";
         default: return "R9";
      endcase
   endfunction

   function automatic int next_val(int v, int op, int ld, int sin, bit up);
      int mask = (1 << W) - 1;
      if (op == 1) return ld;
      if (op == 2) return up ? (((v << 1) | sin) & mask) : ((v >> 1) | (sin << (W - 1)));
      return v;
   endfunction

   function automatic string op_tag(int op, int code);
      if (op == 2) return sin_tag(code);
      return "R2";
   endfunction

   task automatic step(bit r, bit up, int rop, int qop, int rld, int qld,
                       int rsel, int qsel, int csel, bit cy, bit sg, bit fl);
      int rso, qso, exp_c, rs, qs;
      @(negedge clk);
      rst = r; dir_up = up; rf_op = 2'(rop); q_op = 2'(qop);
      rf_load_data = W'(rld); q_load_data = W'(qld);
      rf_sin_sel = 3'(rsel); q_sin_sel = 3'(qsel); cin_sel = 3'(csel);
      alu_carry = cy; alu_sign = sg; flag_latched = fl;
      #1;
      if (model_ok) begin
         check(rf_tag, "rf_value", int'(rf_value), m_rf);
         check(q_tag, "q_value", int'(q_value), m_q);
         rso = end_bit(m_rf, up);
         qso = end_bit(m_q, up);
         // R3 / R4: end bit visible regardless of op
         check(rop == 2 ? "R3" : "R4", "rf_shift_out", int'(rf_shift_out), rso);
         check(qop == 2 ? "R3" : "R4", "q_shift_out", int'(q_shift_out), qso);
         case (csel)
            0: exp_c = 0;
            1: exp_c = 1;
            2: exp_c = rso;
            3: exp_c = qso;
            6: exp_c = int'(cy);
            7: exp_c = int'(sg);
            default: exp_c = 0;
         endcase
         check((csel == 4 || csel == 5) ? "R11" : "R10", "carry_in", int'(carry_in), exp_c);
         rs = pick_sin(rsel, rso, qso);
         qs = pick_sin(qsel, qso, rso);
         if (r) begin
            m_rf = 0; m_q = 0; rf_tag = "R1"; q_tag = "R1";
         end else begin
            m_rf = next_val(m_rf, rop, rld & 255, rs, up);
            m_q  = next_val(m_q, qop, qld & 255, qs, up);
            rf_tag = op_tag(rop, rsel);
            q_tag  = op_tag(qop, qsel);
         end
      end else if (r) begin
         m_rf = 0; m_q = 0; model_ok = 1; rf_tag = "R1"; q_tag = "R1";
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      // R1: reset with loads requested, reset wins
      step(1, 1, 1, 1, 8'hFF, 8'hFF, 0, 0, 0, 0, 0, 0);
      step(1, 1, 1, 1, 8'hFF, 8'hFF, 0, 0, 0, 0, 0, 0);
      // R2: loads then holds with code 3
      step(0, 1, 1, 1, 8'hA5, 8'h3C, 0, 0, 0, 0, 0, 0);
      step(0, 0, 3, 0, 8'h00, 8'h00, 1, 1, 2, 0, 0, 0);
      step(0, 1, 0, 3, 8'h11, 8'h22, 1, 1, 3, 0, 0, 0);
      // R6: rotate up and down
      for (int i = 0; i < 9; i++) step(0, 1, 2, 0, 0, 0, 2, 0, 2, 0, 0, 0);
      for (int i = 0; i < 9; i++) step(0, 0, 0, 2, 0, 0, 0, 2, 3, 0, 0, 0);
      // R7: cross-chain both directions
      for (int i = 0; i < 8; i++) step(0, i[0], 2, 2, 0, 0, 3, 3, 4, 1, 1, 1);
      // R5, R8, R9: fill sources
      for (int c = 0; c < 8; c++)
         for (int d = 0; d < 2; d++)
            step(0, d[0], 2, 2, 0, 0, c, 7 - c, 5, c[0], c[1], c[2]);
      // R10, R11: every carry select against varied shift-outs
      for (int c = 0; c < 8; c++) begin
         step(0, 1, 1, 1, 8'h80, 8'h01, 0, 0, c, 1, 0, 0);
         step(0, 0, 0, 0, 0, 0, 0, 0, c, 0, 1, 0);
         step(0, 1, 0, 0, 0, 0, 0, 0, c, 1, 1, 0);
      end
      // mixed random traffic
      for (int i = 0; i < 3000; i++)
         step(($urandom % 61) == 0, 1'($urandom), int'($urandom % 4), int'($urandom % 4),
              int'($urandom % 256), int'($urandom % 256), int'($urandom % 8),
              int'($urandom % 8), int'($urandom % 8), 1'($urandom), 1'($urandom),
              1'($urandom));
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule